// File: doc/BRIEF.md
# Pseudo-SRAM Refresh Scheduler

This block schedules the distributed refresh of a self-refreshing DRAM that sits behind a serial interface with one active-low chip select. A free-running timer raises one refresh request per row interval. Requests wait in a saturating counter. An internal refresh starts only while the chip select is high, and each one occupies the array for a fixed number of cycles. The refresh row pointer advances by one for every refresh. Automatic refresh has no enable and cannot be switched off.

A refresh that has started is never cut short. If the host lowers chip select while a refresh is still running, the block raises RWDS during the command/address phase of that transaction, and the initial latency it reports is doubled. A host access to the row the scheduler would refresh next counts as a refresh of that row and retires one pending request.

The block also counts how long chip select stays low. It raises a sticky flag when the low time exceeds the selected limit, which is the base limit times 1, 1.5, 2 or 4.

Top module: `psram_refresh_sched`

## Requirements
- R1: After reset the outputs are as follows: busy 0, pending 0, RWDS 0, violation flag 0, and latency equal to BASE_LAT.
- R2: The pending count rises by one at the INTERVAL_CYC-th active clock edge after reset, and again every INTERVAL_CYC edges after that. It saturates at its maximum.
- R3: A refresh starts only at a clock edge that samples cs_ni high while the pending count is nonzero. The start lowers the pending count by one. Busy then stays high for exactly TRFH_CYC cycles. Refreshed rows follow the sequence 0, 1, 2, and so on.
- R4: A refresh in progress runs to completion even if chip select goes low during it.
- R5: If busy is high at the clock edge that first samples cs_ni low, rwds_o is high while ca_phase_i is high in that transaction, and lat_o reads 2*BASE_LAT until chip select returns high.
- R6: If busy is low when chip select falls, rwds_o stays 0 and lat_o reads BASE_LAT.
- R7: No refresh starts while chip select is low, so requests accumulate. Once chip select is high, the pending refreshes run back-to-back: the next one starts at the same edge at which the previous one ends.
- R8: A host access (acc_valid_i with cs_ni low) to the row the scheduler would refresh next retires one pending request and advances the pointer. An access to any other row leaves the pending count unchanged.
- R9: tcms_sel_i selects the limit: 0 gives 1x, 1 gives 1.5x, 2 gives 2x and 3 gives 4x TCMS_CYC. tcms_viol_o rises at the edge at which cs_ni has been sampled low for limit+1 consecutive edges, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ca_phase_i | input | 1 | High during the command/address phase |
| acc_valid_i | input | 1 | A host access to acc_row_i is taking place |
| acc_row_i | input | ROW_W | Row of the host access |
| tcms_sel_i | input | 2 | Chip-select low-time limit multiplier |
| rwds_o | output | 1 | Extra-latency request |
| lat_o | output | LAT_W | Initial latency count for the current transaction |
| rfsh_busy_o | output | 1 | Internal refresh in progress |
| rfsh_row_o | output | ROW_W | Row of the current or last refresh |
| pend_o | output | PEND_W | Refresh requests waiting |
| tcms_viol_o | output | 1 | Sticky chip-select low-time violation |

## Verification
The bench lowers chip select during a running refresh and checks that RWDS and the doubled latency appear. A design that sampled busy too late would drop the request, and one that aborted the refresh would clear busy early. It holds chip select low across several timer ticks and checks that no refresh starts until chip select rises, and that the stored requests then run back-to-back with no idle gap. It sends host accesses to the next row and to a different row; a wrong row compare would retire requests it should not retire. The violation flag is checked one cycle either side of its threshold, at 1x and under the 4x setting, so an off-by-one compare, a wrong multiplier or a flag that clears itself is caught.

// File: rtl/psram_rfsh_pkg.sv
package psram_rfsh_pkg;

  typedef enum logic [1:0] {
    TCMS_X1   = 2'd0,
    TCMS_X1P5 = 2'd1,
    TCMS_X2   = 2'd2,
    TCMS_X4   = 2'd3
  } tcms_mult_e;

  // Scaled chip-select low limit in cycles
  function automatic int unsigned tcms_limit(int unsigned base, logic [1:0] sel);
    case (tcms_mult_e'(sel))
      TCMS_X1:   return base;
      TCMS_X1P5: return base + base / 2;
      TCMS_X2:   return 2 * base;
      default:   return 4 * base;
    endcase
  endfunction

endpackage

// File: rtl/psram_due_timer.sv
module psram_due_timer #(
  parameter int INTERVAL_CYC = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = $clog2(INTERVAL_CYC);

  logic [TW-1:0] tmr_q;

  assign tick_o = (tmr_q == TW'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmr_q <= '0;
    else if (tick_o) tmr_q <= '0;
    else             tmr_q <= tmr_q + 1'b1;
  end

endmodule

// File: rtl/psram_cs_watch.sv
module psram_cs_watch
  import psram_rfsh_pkg::*;
#(
  parameter int TCMS_CYC = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic [1:0] tcms_sel_i,
  output logic       cs_fall_o,
  output logic       viol_o
);
  localparam int LO_W = $clog2(4 * TCMS_CYC + 2);

  logic            cs_q;
  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lim;
  logic            viol_q;

  assign lim       = LO_W'(tcms_limit(TCMS_CYC, tcms_sel_i));
  assign cs_fall_o = cs_q & ~cs_ni;
  assign viol_o    = viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      lo_q   <= '0;
      viol_q <= 1'b0;
    end else begin
      cs_q <= cs_ni;
      if (cs_ni)              lo_q <= '0;
      else if (lo_q != '1)    lo_q <= lo_q + 1'b1;
      if (!cs_ni && lo_q >= lim) viol_q <= 1'b1;
    end
  end

  a_r9_viol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> viol_q);

  a_r9_viol_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(viol_q) |-> !$past(cs_ni));

endmodule

// File: rtl/psram_rfsh_engine.sv
module psram_rfsh_engine #(
  parameter int ROW_W    = 13,
  parameter int PEND_W   = 4,
  parameter int TRFH_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cs_high_i,
  input  logic             acc_valid_i,
  input  logic [ROW_W-1:0] acc_row_i,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o,
  output logic [PEND_W-1:0] pend_o
);
  localparam int TW = (TRFH_CYC > 1) ? $clog2(TRFH_CYC) : 1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              busy_q;
  logic [TW-1:0]     dur_q;
  logic [ROW_W-1:0]  ptr_q, row_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              start, retire, inc, dec;

  // Start only in a chip-select-high window; chain on the last busy cycle
  assign start  = cs_high_i && (pend_q != '0) && (!busy_q || dur_q == '0);
  // Host access to the next row counts as its refresh
  assign retire = acc_valid_i && !cs_high_i && (acc_row_i == ptr_q) && (pend_q != '0);
  assign inc    = tick_i && (pend_q != PEND_MAX);
  assign dec    = start | retire;

  always_comb begin
    case ({inc, dec})
      2'b10:   pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dur_q  <= '0;
      ptr_q  <= '0;
      row_q  <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (start) begin
        busy_q <= 1'b1;
        dur_q  <= TW'(TRFH_CYC - 1);
        row_q  <= ptr_q;
      end else if (busy_q) begin
        if (dur_q == '0) busy_q <= 1'b0;
        else             dur_q  <= dur_q - 1'b1;
      end
      if (dec) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign row_o  = row_q;
  assign pend_o = pend_q;

  a_r3_start_in_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(cs_high_i));

  a_r4_no_cut_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dur_q != '0) |=> busy_q);

  a_r2_tick_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> pend_q != '0);

  a_r8_retire_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_high_i && !tick_i && pend_q == '0) |=> pend_q == '0);

endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched
  import psram_rfsh_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int PEND_W       = 4,
  parameter int INTERVAL_CYC = 781,
  parameter int TRFH_CYC     = 4,
  parameter int TCMS_CYC     = 400,
  parameter int BASE_LAT     = 4,
  parameter int LAT_W        = $clog2(2 * BASE_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ca_phase_i,
  input  logic              acc_valid_i,
  input  logic [ROW_W-1:0]  acc_row_i,
  input  logic [1:0]        tcms_sel_i,
  output logic              rwds_o,
  output logic [LAT_W-1:0]  lat_o,
  output logic              rfsh_busy_o,
  output logic [ROW_W-1:0]  rfsh_row_o,
  output logic [PEND_W-1:0] pend_o,
  output logic              tcms_viol_o
);
  logic tick, cs_fall, busy, xlat_q, xlat_now;

  psram_due_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  psram_cs_watch #(.TCMS_CYC(TCMS_CYC)) u_cs_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni     (cs_ni),
    .tcms_sel_i(tcms_sel_i),
    .cs_fall_o (cs_fall),
    .viol_o    (tcms_viol_o)
  );

  psram_rfsh_engine #(
    .ROW_W   (ROW_W),
    .PEND_W  (PEND_W),
    .TRFH_CYC(TRFH_CYC)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cs_high_i  (cs_ni),
    .acc_valid_i(acc_valid_i),
    .acc_row_i  (acc_row_i),
    .busy_o     (busy),
    .row_o      (rfsh_row_o),
    .pend_o     (pend_o)
  );

  // Extra-latency decision is taken once, at the chip-select fall
  assign xlat_now = cs_fall ? busy : xlat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      xlat_q <= 1'b0;
    else if (cs_ni)   xlat_q <= 1'b0;
    else if (cs_fall) xlat_q <= busy;
  end

  assign rwds_o      = ~cs_ni & ca_phase_i & xlat_now;
  assign lat_o       = xlat_now ? LAT_W'(2 * BASE_LAT) : LAT_W'(BASE_LAT);
  assign rfsh_busy_o = busy;

  a_r5_lat_fixed_in_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !cs_fall) |-> $stable(lat_o));

  a_r6_idle_fall_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall && !busy) |-> (!rwds_o && lat_o == LAT_W'(BASE_LAT)));

endmodule

// File: tb/tb_psram_refresh_sched.sv
module tb_psram_refresh_sched;
  localparam int ROW_W = 8, PEND_W = 4, INTERVAL = 40, TRFH = 4, TCMS = 16, BLAT = 3;
  localparam int LAT_W = $clog2(2 * BLAT + 1);

  logic clk = 0, rst_ni = 0;
  logic cs_ni = 1, ca_phase_i = 0, acc_valid_i = 0;
  logic [ROW_W-1:0] acc_row_i = '0;
  logic [1:0] tcms_sel_i = 2'd0;
  logic rwds_o, rfsh_busy_o, tcms_viol_o;
  logic [LAT_W-1:0] lat_o;
  logic [ROW_W-1:0] rfsh_row_o;
  logic [PEND_W-1:0] pend_o;

  always #2.5 clk = ~clk;

  psram_refresh_sched #(
    .ROW_W(ROW_W), .PEND_W(PEND_W), .INTERVAL_CYC(INTERVAL),
    .TRFH_CYC(TRFH), .TCMS_CYC(TCMS), .BASE_LAT(BLAT)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ca_phase_i(ca_phase_i),
    .acc_valid_i(acc_valid_i), .acc_row_i(acc_row_i), .tcms_sel_i(tcms_sel_i),
    .rwds_o(rwds_o), .lat_o(lat_o), .rfsh_busy_o(rfsh_busy_o),
    .rfsh_row_o(rfsh_row_o), .pend_o(pend_o), .tcms_viol_o(tcms_viol_o)
  );

  typedef enum int {S_BUSY, S_ROW, S_PEND, S_RWDS, S_LAT, S_VIOL} sig_e;
  typedef struct { int cyc; sig_e sig; int val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  function automatic int sample(sig_e s);
    case (s)
      S_BUSY: return int'(rfsh_busy_o);
      S_ROW:  return int'(rfsh_row_o);
      S_PEND: return int'(pend_o);
      S_RWDS: return int'(rwds_o);
      S_LAT:  return int'(lat_o);
      default: return int'(tcms_viol_o);
    endcase
  endfunction

  task automatic push(int c, sig_e s, int v, string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // Monitor: compare design outputs against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      int a;
      e = q.pop_front();
      a = sample(e.sig);
      n_run++;
      if (e.cyc != cyc || a != e.val) begin
        n_fail++;
        $display("FAIL %s cyc=%0d sig=%s actual=%0d expected=%0d",
                 e.req, e.cyc, e.sig.name(), a, e.val);
      end
    end
  end

  task automatic at(int n);
    forever begin
      @(posedge clk); #1;
      if (cyc >= n) break;
    end
  endtask

  initial begin
    // R1 reset state
    push(0, S_BUSY, 0, "R1"); push(0, S_PEND, 0, "R1"); push(0, S_RWDS, 0, "R1");
    push(0, S_VIOL, 0, "R1"); push(0, S_LAT, BLAT, "R1");
    // R2 first tick, R3 first refresh on row 0
    push(39, S_PEND, 0, "R2"); push(40, S_PEND, 1, "R2"); push(40, S_BUSY, 0, "R3");
    push(41, S_BUSY, 1, "R3"); push(41, S_PEND, 0, "R3"); push(41, S_ROW, 0, "R3");
    push(44, S_BUSY, 1, "R3"); push(45, S_BUSY, 0, "R3");
    // R5/R4 fall during refresh of row 1
    push(81, S_RWDS, 1, "R5"); push(81, S_LAT, 2*BLAT, "R5"); push(81, S_ROW, 1, "R3");
    push(82, S_RWDS, 1, "R5"); push(83, S_RWDS, 0, "R5"); push(83, S_LAT, 2*BLAT, "R5");
    push(84, S_BUSY, 1, "R4"); push(85, S_BUSY, 0, "R4"); push(88, S_LAT, BLAT, "R5");
    // R6 idle fall; R7 deferral; R8 implicit refresh
    push(110, S_RWDS, 0, "R6"); push(110, S_LAT, BLAT, "R6");
    push(120, S_PEND, 1, "R2"); push(121, S_BUSY, 0, "R7");
    push(122, S_PEND, 1, "R8"); push(123, S_PEND, 0, "R8");
    push(124, S_BUSY, 0, "R7"); push(125, S_VIOL, 0, "R9");
    push(130, S_BUSY, 0, "R8"); push(161, S_BUSY, 1, "R8"); push(161, S_ROW, 3, "R8");
    // R7 accumulation and back-to-back, R9 4x setting
    push(240, S_PEND, 2, "R7"); push(241, S_BUSY, 0, "R7"); push(243, S_VIOL, 0, "R9");
    push(244, S_BUSY, 1, "R7"); push(244, S_ROW, 4, "R7"); push(244, S_PEND, 1, "R7");
    push(247, S_BUSY, 1, "R7"); push(248, S_BUSY, 1, "R7"); push(248, S_ROW, 5, "R7");
    push(248, S_PEND, 0, "R7"); push(252, S_BUSY, 0, "R7");
    // R9 violation at 1x and stickiness
    push(276, S_VIOL, 0, "R9"); push(277, S_VIOL, 1, "R9"); push(295, S_VIOL, 1, "R9");

    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    at(81);  cs_ni = 0; ca_phase_i = 1;
    at(83);  ca_phase_i = 0;
    at(86);  cs_ni = 1;
    at(110); cs_ni = 0; ca_phase_i = 1;
    at(112); ca_phase_i = 0;
    at(121); acc_valid_i = 1; acc_row_i = 8'd5;
    at(122); acc_row_i = 8'd2;
    at(123); acc_valid_i = 0;
    at(125); cs_ni = 1;
    at(195); cs_ni = 0; tcms_sel_i = 2'd3;
    at(243); cs_ni = 1;
    at(255); tcms_sel_i = 2'd0;
    at(260); cs_ni = 0;
    at(280); cs_ni = 1;
    at(300);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL pending expectations left=%0d actual=%0d expected=0", q.size(), q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule